// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional predicate holds, given the condition-code bits of a 32-bit floating-point status word. Conditional branches, set-on-condition and decrement-and-branch operations all use it. Each request supplies a 5-bit selector. The low four bits pick one of sixteen IEEE ordered or unordered predicates. The top bit marks the predicate as signaling: in that case an unordered comparison sets two exception bits in the status word.

The caller raises `req_i` for one cycle together with the selector and the current status word. One clock edge later, `valid_o` pulses and the block presents the true/false outcome and the status word to write back. Both outputs hold their value until the next request. Instruction decode, address generation, program-counter update and memory writes are done by the surrounding logic.

Top module: `fpc_cond_eval`

## Requirements
- R1: While `rst_n` is low at a clock edge, `valid_o`, `cond_o` and `stat_o` are cleared to zero at that edge.
- R2: `valid_o` is 1 in the cycle after each cycle in which `req_i` is 1, and 0 after any cycle in which `req_i` is 0.
- R3: After a cycle with `req_i` at 0, `cond_o` and `stat_o` keep their previous values, whatever is on `sel_i` and `stat_i`.
- R4: The condition flags are read from `stat_i`: unordered (U) at bit 24, zero (Z) at bit 26, negative (N) at bit 27. For code `sel_i[3:0]` 0 the result is 0, for 15 it is 1, for 1 (eq) it is Z, for 14 (ne) it is not Z, and for 8 (un) it is U.
- R5: Strict ordered predicates are 0 whenever U is 1. Otherwise: code 2 (ogt) is !Z&!N, code 4 (olt) is N&!Z, code 6 (ogl) is !Z, and code 7 (or) is 1.
- R6: Code 3 (oge) is Z | (!U & !N). Code 5 (ole) is Z | (!U & N).
- R7: Unordered predicates are 1 whenever U is 1. Otherwise: code 9 (ueq) is Z, code 10 (ugt) is !N&!Z, and code 12 (ult) is N&!Z.
- R8: Code 11 (uge) is U | Z | !N. Code 13 (ule) is U | Z | N.
- R9: When `sel_i[4]` is 1 and U is 1, `stat_o` equals `stat_i` with bits 15 and 7 both forced to 1. All other bits are unchanged.
- R10: When `sel_i[4]` is 0 or U is 0, `stat_o` equals `stat_i` exactly. The value of `sel_i[4]` never changes `cond_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Evaluation request strobe |
| sel_i | input | 5 | Bit 4: signaling; bits 3:0: predicate code |
| stat_i | input | 32 | Current floating-point status word |
| valid_o | output | 1 | Result valid, one cycle after request |
| cond_o | output | 1 | Predicate outcome |
| stat_o | output | 32 | Status word to write back |

## Verification
The main sweep runs all 32 selector values against all eight combinations of the U, Z and N flags. Each request carries random bits in the rest of the status word. This separates every predicate from its neighbours: oge and uge, for example, differ only when U is set, and ueq and eq differ only when U is set and Z is clear. Pairing each code with and without the signaling bit shows that bits 15 and 7 are raised only for a signaling selector with U set, and that no other status bit changes. Idle cycles with changing inputs, plus a request held during reset, show that the outputs hold between requests and that reset clears them.

// File: rtl/fpc_pkg.sv
// Package fpc_pkg
// Shared widths, flag positions and the predicate code enumeration for the
// floating-point condition evaluator. Bit positions are fixed by the status
// word layout that the surrounding unit uses.
package fpc_pkg;

    localparam int STAT_W   = 32;
    localparam int SEL_W    = 5;
    localparam int CODE_W   = SEL_W - 1;
    localparam int SIG_BIT  = SEL_W - 1;

    localparam int UNORD_POS = 24;
    localparam int ZERO_POS  = 26;
    localparam int NEG_POS   = 27;
    localparam int EXC_POS   = 15;
    localparam int ACC_POS   = 7;

    typedef enum logic [3:0] {
        PC_FALSE = 4'd0,
        PC_EQ    = 4'd1,
        PC_OGT   = 4'd2,
        PC_OGE   = 4'd3,
        PC_OLT   = 4'd4,
        PC_OLE   = 4'd5,
        PC_OGL   = 4'd6,
        PC_OR    = 4'd7,
        PC_UN    = 4'd8,
        PC_UEQ   = 4'd9,
        PC_UGT   = 4'd10,
        PC_UGE   = 4'd11,
        PC_ULT   = 4'd12,
        PC_ULE   = 4'd13,
        PC_NE    = 4'd14,
        PC_TRUE  = 4'd15
    } pred_code_e;

    typedef struct packed {
        logic unord;
        logic zero;
        logic neg;
    } cc_flags_t;

endpackage

// File: rtl/fpc_status_path.sv
// Module fpc_status_path
// Reads the three condition flags out of the status word and builds the
// status word to write back. When the selector is signaling and the
// unordered flag is set, the exception bit and the accrued bit are forced
// high. Purely combinational; assumes the flag and exception positions
// given by the parameters lie inside the word.
module fpc_status_path
    import fpc_pkg::*;
#(
    parameter int W       = STAT_W,
    parameter int U_POS   = UNORD_POS,
    parameter int Z_POS   = ZERO_POS,
    parameter int N_POS   = NEG_POS,
    parameter int E_POS   = EXC_POS,
    parameter int A_POS   = ACC_POS
) (
    input  logic [W-1:0] stat_in,
    input  logic         signaling,
    output cc_flags_t    flags,
    output logic [W-1:0] stat_next
);

    localparam logic [W-1:0] RAISE_MASK = (W'(1) << E_POS) | (W'(1) << A_POS);

    // Pick the condition flags out of the status word.
    always_comb begin
        flags.unord = stat_in[U_POS];
        flags.zero  = stat_in[Z_POS];
        flags.neg   = stat_in[N_POS];
    end

    // Merge in the exception bits only for a signaling unordered case.
    always_comb begin
        if (signaling && stat_in[U_POS])
            stat_next = stat_in | RAISE_MASK;
        else
            stat_next = stat_in;
    end

endmodule

// File: rtl/fpc_pred_eval.sv
// Module fpc_pred_eval
// Maps a 4-bit predicate code and the three condition flags to a single
// truth value. Purely combinational; the code is taken as one of the sixteen
// values of pred_code_e, so every code has a defined result.
module fpc_pred_eval
    import fpc_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0] code,
    input  cc_flags_t     flags,
    output logic          holds
);

    logic u, z, n;
    logic ordered;
    logic greater;
    logic less;

    // Derive the basic relations shared by several predicates.
    always_comb begin
        u       = flags.unord;
        z       = flags.zero;
        n       = flags.neg;
        ordered = !u;
        greater = !z && !n;
        less    = n && !z;
    end

    // Select the predicate outcome for the requested code.
    always_comb begin
        unique case (pred_code_e'(code))
            PC_FALSE: holds = 1'b0;
            PC_EQ:    holds = z;
            PC_OGT:   holds = ordered && greater;
            PC_OGE:   holds = z || (ordered && !n);
            PC_OLT:   holds = ordered && less;
            PC_OLE:   holds = z || (ordered && n);
            PC_OGL:   holds = ordered && !z;
            PC_OR:    holds = ordered;
            PC_UN:    holds = u;
            PC_UEQ:   holds = u || z;
            PC_UGT:   holds = u || greater;
            PC_UGE:   holds = u || z || !n;
            PC_ULT:   holds = u || less;
            PC_ULE:   holds = u || z || n;
            PC_NE:    holds = !z;
            PC_TRUE:  holds = 1'b1;
            default:  holds = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpc_cond_eval.sv
// Module fpc_cond_eval (top)
// Evaluates a floating-point conditional predicate against the status word
// and returns the outcome plus the status word to write back. The result is
// registered once: valid_o pulses in the cycle after req_i, and the outputs
// hold between requests. Reset is synchronous and active low.
module fpc_cond_eval
    import fpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              valid_o,
    output logic              cond_o,
    output logic [STAT_W-1:0] stat_o
);

    cc_flags_t         flags;
    logic [STAT_W-1:0] stat_next;
    logic              holds;

    fpc_status_path #(
        .W     (STAT_W),
        .U_POS (UNORD_POS),
        .Z_POS (ZERO_POS),
        .N_POS (NEG_POS),
        .E_POS (EXC_POS),
        .A_POS (ACC_POS)
    ) u_status (
        .stat_in   (stat_i),
        .signaling (sel_i[SIG_BIT]),
        .flags     (flags),
        .stat_next (stat_next)
    );

    fpc_pred_eval #(
        .CW (CODE_W)
    ) u_pred (
        .code  (sel_i[CODE_W-1:0]),
        .flags (flags),
        .holds (holds)
    );

    // Valid strobe follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= req_i;
    end

    // Capture outcome and write-back status on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_o <= 1'b0;
            stat_o <= '0;
        end else if (req_i) begin
            cond_o <= holds;
            stat_o <= stat_next;
        end
    end

    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(cond_o) && $stable(stat_o)));

    a_r4_const_true: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i[CODE_W-1:0] == PC_TRUE) |=> cond_o);

    a_r4_const_false: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i[CODE_W-1:0] == PC_FALSE) |=> !cond_o);

    a_r9_raise_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i[SIG_BIT] && stat_i[UNORD_POS])
            |=> (stat_o[EXC_POS] && stat_o[ACC_POS]));

    a_r10_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !sel_i[SIG_BIT]) |=> (stat_o == $past(stat_i)));

    a_r7_unord_true: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && stat_i[UNORD_POS] && sel_i[CODE_W-1] && sel_i[CODE_W-2:0] != 3'd6
            && sel_i[CODE_W-2:0] != 3'd7) |=> cond_o);

endmodule

// File: tb/tb_fpc_cond_eval.sv
module tb_fpc_cond_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [4:0]  sel_i = '0;
    logic [31:0] stat_i = '0;
    logic        valid_o;
    logic        cond_o;
    logic [31:0] stat_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        c;
        logic [31:0] s;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    fpc_cond_eval dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_i(sel_i),
        .stat_i(stat_i), .valid_o(valid_o), .cond_o(cond_o), .stat_o(stat_o)
    );

    // Behavioural truth of a predicate in terms of comparison outcomes.
    function automatic logic model(input int code, input bit u, input bit z, input bit n);
        bit eq, lt, gt;
        eq = z;
        lt = n && !z;
        gt = !n && !z;
        case (code)
            0:  return 0;
            1:  return eq;
            2:  return !u && gt;
            3:  return eq || (!u && !n);
            4:  return !u && lt;
            5:  return eq || (!u && n);
            6:  return !u && !eq;
            7:  return !u;
            8:  return u;
            9:  return u ? 1'b1 : eq;
            10: return u ? 1'b1 : gt;
            11: return u ? 1'b1 : (eq || !n);
            12: return u ? 1'b1 : lt;
            13: return u ? 1'b1 : (eq || n);
            14: return !eq;
            default: return 1;
        endcase
    endfunction

    function automatic string tag(input int code);
        case (code)
            0, 1, 8, 14, 15: return "R4";
            2, 4, 6, 7:      return "R5";
            3, 5:            return "R6";
            11, 13:          return "R8";
            default:         return "R7";
        endcase
    endfunction

    task automatic check_bit(input string r, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", r, what, act, exp);
        end
    endtask

    task automatic check_word(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s stat_o actual=%08h expected=%08h", r, act, exp);
        end
    endtask

    // One request, then compare the following cycle against the queued model.
    task automatic do_req(input logic [4:0] sel, input logic [31:0] st);
        exp_t e;
        int code;
        bit u, z, n;
        code = int'(sel[3:0]);
        u = st[24]; z = st[26]; n = st[27];
        e.c = model(code, u, z, n);
        e.s = (sel[4] && u) ? (st | 32'h0000_8080) : st;
        expq.push_back(e);
        @(negedge clk);
        req_i = 1'b1; sel_i = sel; stat_i = st;
        @(posedge clk); #1;
        e = expq.pop_front();
        check_bit("R2", valid_o, 1'b1, "valid_o");
        check_bit(tag(code), cond_o, e.c, $sformatf("cond_o code=%0d sel4=%0b uzn=%0b%0b%0b", code, sel[4], u, z, n));
        check_word((sel[4] && u) ? "R9" : "R10", stat_o, e.s);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic hc;
        logic [31:0] hs;
        // R1: request asserted during reset must not leave anything behind
        @(negedge clk);
        req_i = 1'b1; sel_i = 5'h0F; stat_i = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R1", valid_o, 1'b0, "valid_o after reset");
        check_bit("R1", cond_o, 1'b0, "cond_o after reset");
        check_word("R1", stat_o, 32'h0);
        @(negedge clk);
        req_i = 1'b0;
        rst_n = 1'b1;

        // R4..R10: every selector against every flag combination
        for (int s = 0; s < 32; s++) begin
            for (int f = 0; f < 8; f++) begin
                logic [31:0] st;
                st = $urandom;
                st[24] = f[0]; st[26] = f[1]; st[27] = f[2];
                if ((f % 3) == 0) begin st[15] = 1'b0; st[7] = 1'b0; end
                do_req(5'(s), st);
            end
        end

        // R2, R3: idle cycles with changing inputs hold outputs
        do_req(5'h11, 32'h0100_0000);
        hc = cond_o; hs = stat_o;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_i = 1'b0; sel_i = 5'(i * 7); stat_i = $urandom;
            @(posedge clk); #1;
            check_bit("R2", valid_o, 1'b0, "valid_o idle");
            check_bit("R3", cond_o, hc, "cond_o held");
            check_word("R3", stat_o, hs);
        end

        // R10: signaling bit never changes the outcome, ordered case
        do_req(5'h19, 32'h0400_0000);
        do_req(5'h09, 32'h0400_0000);

        // R1: reset in the middle clears held outputs
        @(negedge clk);
        req_i = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        check_bit("R1", valid_o, 1'b0, "valid_o in reset");
        check_bit("R1", cond_o, 1'b0, "cond_o in reset");
        check_word("R1", stat_o, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule